// File: doc/BRIEF.md
# Two-Level Interrupt Status Collector

This unit gathers interrupt events from two groups of sources into two sticky status registers. Each status register has a mask register beside it, and the two are matched bit for bit. A single level-sensitive request line goes to the host. It is high while any pending event is enabled by its mask.

Bit 0 of the second status register is a chain bit. It is set while any enabled event is pending in the first register. A host that takes the request first reads the second register. If the cause is in that register, the host has found it. If the chain bit is set, one more read of the first register gives the cause. No cause needs more than two reads.

Reading a status register clears its event bits. An event that arrives in the same cycle as the clearing read is not lost. Masks control only the request line and the chain bit. A masked event is still recorded in its status register.

Top module: `irq_chain_unit`

## Requirements
- R1: After reset, both status registers read 0 except the chain bit (which is also 0). Mask A reads 0, mask B reads 1 (only bit 0 set), and `irq` is low.
- R2: An event input bit that is high for one cycle sets the matching status bit from the next cycle on. The bit stays set until its register is read.
- R3: A read (`rd_en` high) at address 0 clears status A. A read at address 1 clears status B bits W-1..1. Each read leaves the other register unchanged.
- R4: An event that arrives in the same cycle as a clearing read of its register is set after that cycle.
- R5: Bit 0 of status B (address 1) reads as the OR of status A ANDed with mask A. A read of status B does not clear it.
- R6: Input `ev_b[0]` has no effect, because that position holds the chain bit.
- R7: Mask A (address 2) and mask B (address 3) are written by `wr_en` and read back. Mask B bit 0 always reads 1 and cannot be written.
- R8: `irq` equals the chain bit ORed with the OR of status B bits W-1..1 ANDed with mask B. It changes one cycle after the event or register update that causes it.
- R9: Writes to addresses 0 and 1 do not change either status register.
- R10: An event whose mask bit is 0 is still recorded in its status register, but it does not raise `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_a | input | W | Event pulses for status A |
| ev_b | input | W | Event pulses for status B (bit 0 unused) |
| addr | input | 2 | Register select: 0 status A, 1 status B, 2 mask A, 3 mask B |
| rd_en | input | 1 | Read strobe. Clears the addressed status register at the clock edge |
| wr_en | input | 1 | Write strobe for the mask registers |
| wdata | input | W | Write data |
| rdata | output | W | Read data for `addr`, taken directly from the current state |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the unit with W = 8. At that width every mask value can be swept in full for both registers. The sweep runs all 256 masks against several event patterns, so every pairing of a pending bit with an enabled or disabled mask bit appears, for both the chain path and the direct path to `irq`. The small width also makes it cheap to test every mask value read back, including the fixed bit 0 of mask B. The same-cycle event and read collision and the ignored inputs are each driven as directed cases.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;

    typedef enum logic [1:0] {
        SEL_STAT_A = 2'd0,
        SEL_STAT_B = 2'd1,
        SEL_MASK_A = 2'd2,
        SEL_MASK_B = 2'd3
    } irq_sel_e;

    localparam int unsigned NUM_BANKS = 2;

endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
    parameter int unsigned W        = 16,
    parameter bit          RSVD_LSB = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ev,
    input  logic         clr,
    output logic [W-1:0] st
);

    typedef struct packed {
        logic [W-1:0] st;
    } bank_state_t;

    bank_state_t  s_d, s_q;
    logic [W-1:0] ev_eff;

    generate
        if (RSVD_LSB) begin : g_rsvd
            assign ev_eff = {ev[W-1:1], 1'b0};
        end else begin : g_full
            assign ev_eff = ev;
        end
    endgenerate

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d.st = '0;
        end
        s_d.st = s_d.st | ev_eff;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign st = s_q.st;

    // R2: without a clear, no set bit drops
    a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((st & $past(st)) == $past(st)));

    // R4: every incoming event is present afterwards, even across a clear
    a_r4_keep: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st & $past(ev_eff)) == $past(ev_eff)));

    // R3: a clear with no new event empties the bank
    a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && (ev_eff == '0)) |=> (st == '0));

endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
    parameter int unsigned W         = 16,
    parameter bit          FIXED_LSB = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mask
);

    typedef struct packed {
        logic [W-1:0] mask;
    } mask_state_t;

    localparam logic [W-1:0] RST_VAL = FIXED_LSB ? W'(1) : '0;

    mask_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr) begin
            s_d.mask = wdata;
        end
        if (FIXED_LSB) begin
            s_d.mask[0] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.mask <= RST_VAL;
        end else begin
            s_q <= s_d;
        end
    end

    assign mask = s_q.mask;

    // R7: mask holds its value unless written
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(mask));

endmodule

// File: rtl/irq_chain_unit.sv
module irq_chain_unit
    import irq_chain_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ev_a,
    input  logic [W-1:0] ev_b,
    input  logic [1:0]   addr,
    input  logic         rd_en,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output logic         irq
);

    logic [W-1:0] ev_arr [NUM_BANKS];
    logic [W-1:0] st_arr [NUM_BANKS];
    logic [W-1:0] mk_arr [NUM_BANKS];
    logic         chain;
    logic         b_pend;
    logic [W-1:0] st_b_view;

    assign ev_arr[0] = ev_a;
    assign ev_arr[1] = ev_b;

    generate
        for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
            logic clr_g;
            logic wr_g;
            assign clr_g = rd_en && (addr == 2'(g));
            assign wr_g  = wr_en && (addr == 2'(g + 2));

            irq_status_bank #(.W(W), .RSVD_LSB(g == 1)) u_stat (
                .clk  (clk),
                .rst_n(rst_n),
                .ev   (ev_arr[g]),
                .clr  (clr_g),
                .st   (st_arr[g])
            );

            irq_mask_bank #(.W(W), .FIXED_LSB(g == 1)) u_mask (
                .clk  (clk),
                .rst_n(rst_n),
                .wr   (wr_g),
                .wdata(wdata),
                .mask (mk_arr[g])
            );
        end
    endgenerate

    always_comb begin
        chain     = |(st_arr[0] & mk_arr[0]);
        b_pend    = |(st_arr[1][W-1:1] & mk_arr[1][W-1:1]);
        st_b_view = {st_arr[1][W-1:1], chain};
        irq       = chain | b_pend;
        unique case (irq_sel_e'(addr))
            SEL_STAT_A: rdata = st_arr[0];
            SEL_STAT_B: rdata = st_b_view;
            SEL_MASK_A: rdata = mk_arr[0];
            default:    rdata = mk_arr[1];
        endcase
    end

    // R5: a set chain bit always raises the request line
    a_r5_chain_irq: assert property (@(posedge clk) disable iff (!rst_n)
        chain |-> irq);

    // R8: an enabled pending B event always raises the request line
    a_r8_b_irq: assert property (@(posedge clk) disable iff (!rst_n)
        b_pend |-> irq);

    // R9: a write to a status address never sets a status bit without an event
    a_r9_no_wr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr[1] && (ev_a == '0)) |=> ((st_arr[0] & ~$past(st_arr[0])) == '0));

endmodule

// File: tb/sim_irq_chain_unit.sv
module sim_irq_chain_unit;

    localparam int unsigned W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] ev_a = '0, ev_b = '0, wdata = '0;
    logic [1:0]   addr = '0;
    logic         rd_en = 1'b0, wr_en = 1'b0;
    logic [W-1:0] rdata;
    logic         irq;

    int n_chk = 0;
    int n_bad = 0;

    logic [W-1:0] m_sa = '0, m_sb = '0, m_ma = '0, m_mb = W'(1);

    always #10 clk = ~clk;

    irq_chain_unit #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .ev_a(ev_a), .ev_b(ev_b), .addr(addr),
        .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        logic chain_e;
        logic irq_e;
        chain_e = |(m_sa & m_ma);
        irq_e   = chain_e | (|(m_sb[W-1:1] & m_mb[W-1:1]));
        addr = 2'd0; #1 chk({req, " statA"}, rdata, m_sa);
        addr = 2'd1; #1 chk({req, " statB"}, rdata, {m_sb[W-1:1], chain_e});
        addr = 2'd2; #1 chk({req, " maskA"}, rdata, m_ma);
        addr = 2'd3; #1 chk({req, " maskB"}, rdata, m_mb);
        chk({req, " irq"}, W'(irq), W'(irq_e));
    endtask

    // one clock with the given stimulus; model follows R2-R4, R6, R7, R9
    task automatic cyc(input logic [W-1:0] ea, input logic [W-1:0] eb, input logic [1:0] ad,
                       input logic r, input logic w, input logic [W-1:0] wd);
        ev_a = ea; ev_b = eb; addr = ad; rd_en = r; wr_en = w; wdata = wd;
        @(posedge clk);
        if (r && ad == 2'd0) m_sa = '0;
        if (r && ad == 2'd1) m_sb = '0;
        m_sa = m_sa | ea;
        m_sb = m_sb | (eb & ~W'(1));
        if (w && ad == 2'd2) m_ma = wd;
        if (w && ad == 2'd3) m_mb = wd | W'(1);
        @(negedge clk);
        ev_a = '0; ev_b = '0; rd_en = 1'b0; wr_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_all("R1_reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1_after");

        // R7: full mask sweep, mask B bit 0 fixed
        for (int v = 0; v < 256; v++) begin
            cyc('0, '0, 2'd2, 1'b0, 1'b1, W'(v));
            cyc('0, '0, 2'd3, 1'b0, 1'b1, W'(v));
            check_all("R7_mask");
        end

        // R8, R10, R5, R3: mask A sweep against patterns
        for (int m = 0; m < 256; m++) begin
            cyc('0, '0, 2'd2, 1'b0, 1'b1, W'(m));
            for (int p = 0; p < 4; p++) begin
                logic [W-1:0] pat;
                pat = W'(8'h01 << p) ^ W'(m * 7 + p * 37);
                cyc(pat, '0, 2'd0, 1'b0, 1'b0, '0);
                check_all("R8_R10_chainA");
                cyc('0, '0, 2'd1, 1'b1, 1'b0, '0);
                check_all("R5_readB_keeps_chain");
                cyc('0, '0, 2'd0, 1'b1, 1'b0, '0);
                check_all("R3_clearA");
            end
        end
        cyc('0, '0, 2'd2, 1'b0, 1'b1, '0);

        // R8, R10, R2, R3: mask B sweep against patterns
        for (int m = 0; m < 256; m++) begin
            cyc('0, '0, 2'd3, 1'b0, 1'b1, W'(m));
            for (int p = 0; p < 4; p++) begin
                logic [W-1:0] pat;
                pat = W'(8'h02 << p) ^ W'(m * 11 + p * 53);
                cyc('0, pat, 2'd0, 1'b0, 1'b0, '0);
                cyc('0, '0, 2'd0, 1'b0, 1'b0, '0);
                check_all("R2_R8_R10_B");
                cyc('0, '0, 2'd0, 1'b1, 1'b0, '0);
                check_all("R3_readA_leaves_B");
                cyc('0, '0, 2'd1, 1'b1, 1'b0, '0);
                check_all("R3_clearB");
            end
        end

        // R4: event collides with clearing read
        cyc(8'hF0, 8'hF0, 2'd0, 1'b0, 1'b0, '0);
        cyc(8'h81, '0, 2'd0, 1'b1, 1'b0, '0);
        addr = 2'd0; #1 chk("R4_collideA", rdata, 8'h81);
        cyc('0, 8'h06, 2'd1, 1'b1, 1'b0, '0);
        addr = 2'd1; #1 chk("R4_collideB", rdata & 8'hFE, 8'h06);
        check_all("R4_all");

        // R6: ev_b bit 0 ignored
        cyc('0, '0, 2'd1, 1'b1, 1'b0, '0);
        cyc('0, '0, 2'd0, 1'b1, 1'b0, '0);
        cyc('0, 8'h01, 2'd0, 1'b0, 1'b0, '0);
        addr = 2'd1; #1 chk("R6_bit0", rdata, 8'h00);
        chk("R6_irq", W'(irq), '0);

        // R9: writes to status addresses have no effect
        cyc(8'h24, 8'h48, 2'd0, 1'b0, 1'b0, '0);
        cyc('0, '0, 2'd0, 1'b0, 1'b1, 8'hFF);
        cyc('0, '0, 2'd1, 1'b0, 1'b1, 8'hFF);
        addr = 2'd0; #1 chk("R9_statA", rdata, 8'h24);
        check_all("R9_all");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule